// File: doc/BRIEF.md
# Bipolar Serial Word Receiver

This block takes 32-bit words sent on two return-to-zero lines. A pulse on one line is a logic one. A pulse on the other line is a logic zero. Sampling runs on a clock enable at four times the bit rate. The receiver finds the start of each pulse and shifts the bit into a word. It marks the end of a word when the lines have been idle long enough to make a three-bit-time gap. It then checks the length, the line pairing and the optional odd parity of the word.

A good word is placed on a holding register and a ready flag is raised. The ready flag stays high until the host acknowledges the word. Three sticky error flags sit at fixed positions in an 8-bit status value: parity, overwritten word and sequence fault. A combined error output is high while any of these flags is set. The flags clear when the host reads the status or when the master reset is asserted.

A self-test input makes the receiver take its lines and its sample enable from a local transmitter instead of the external pins.

Top module: `bipolar_word_rx`

## Requirements
- R1: Line samples are taken only on clock cycles where the selected sample enable is high. With that enable held low, activity on the lines changes neither word_ready nor status.
- R2: A bit starts on a sample where exactly one line is high and the previous sample had both lines low. A pulse on line_one gives 1 and a pulse on line_zero gives 0. The first bit received lands in word_out bit 0, and later bits fill the higher positions.
- R3: After exactly 32 bits, a gap closes on the 12th consecutive sample with both lines low. When the gap closes, word_out is loaded and word_ready goes high on the next clock.
- R4: A sample with both lines high sets status bit 5 (sequence fault). The word in progress is then discarded, so word_ready does not rise.
- R5: If between 1 and 31 bits arrive before a gap, status bit 5 is set and no word is delivered.
- R6: A 33rd bit before the gap sets status bit 5 and the word is discarded.
- R7: When parity_en is high, a delivered word with an even number of ones sets status bit 3 and is still delivered. When parity_en is low, status bit 3 is never set.
- R8: If a word is delivered while word_ready is already high and word_ack is low, status bit 4 is set and word_out takes the new word.
- R9: word_ack clears word_ready on the next clock. If a word is delivered in the same cycle as word_ack, word_ready stays high and status bit 4 stays clear.
- R10: stat_rd clears status bits 3 to 5 on the next clock. An error raised in the same cycle as stat_rd is still recorded.
- R11: err_any is high exactly when any of status bits 3, 4 or 5 is set. All other status bits read 0.
- R12: mr (active high, synchronous) clears word_ready, all error flags and any partly received word.
- R13: When self_test is high, the lines come from lb_one/lb_zero and the sample enable from tx_ce. line_one, line_zero and rx_ce are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr | input | 1 | Master reset, synchronous, active high |
| rx_ce | input | 1 | External sample enable, four per bit |
| line_one | input | 1 | External line carrying one-bits |
| line_zero | input | 1 | External line carrying zero-bits |
| tx_ce | input | 1 | Transmitter sample enable used in self-test |
| lb_one | input | 1 | Transmitter one-line for loopback |
| lb_zero | input | 1 | Transmitter zero-line for loopback |
| self_test | input | 1 | Selects loopback lines and enable |
| parity_en | input | 1 | Enables the odd parity check |
| word_ack | input | 1 | Host acknowledges the held word |
| stat_rd | input | 1 | Host reads status; clears error flags |
| word_out | output | 32 | Last delivered word, first bit in bit 0 |
| word_ready | output | 1 | A delivered word is waiting |
| status | output | 8 | Bit 3 parity, bit 4 overwrite, bit 5 sequence |
| err_any | output | 1 | Any error flag set |

## Verification
Two cases are hard to reach from the ports. In one, word_ack arrives in the very cycle a new word completes. In the other, a line clash arrives in the very cycle the status is read. To land on those cycles, the stimulus counts null samples exactly. The gap closes on the tenth null after a bit's two trailing lows, so the host strobe is driven on that sample. Length faults are swept for every short count from 1 to 31 and for an overlong word. The master-reset check stops a half-sent word and then sends a full one. Without the reset, the two parts would join into an overlong word and raise a fault.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  localparam int unsigned ST_W   = 8;
  localparam int unsigned ST_PAR = 3;
  localparam int unsigned ST_OVW = 4;
  localparam int unsigned ST_SEQ = 5;
endpackage

// File: rtl/bwr_line_sel.sv
module bwr_line_sel (
  input  logic ext_one,
  input  logic ext_zero,
  input  logic ext_ce,
  input  logic lb_one,
  input  logic lb_zero,
  input  logic lb_ce,
  input  logic self_test,
  output logic smp_one,
  output logic smp_zero,
  output logic smp_ce
);
  always_comb begin
    if (self_test) begin
      smp_one  = lb_one;
      smp_zero = lb_zero;
      smp_ce   = lb_ce;
    end else begin
      smp_one  = ext_one;
      smp_zero = ext_zero;
      smp_ce   = ext_ce;
    end
  end
endmodule

// File: rtl/bwr_pulse_gap.sv
module bwr_pulse_gap #(
  parameter int unsigned GAP_SMP = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr,
  input  logic ce,
  input  logic one,
  input  logic zero,
  output logic bit_stb,
  output logic bit_val,
  output logic clash,
  output logic gap_stb
);
  localparam int unsigned NW = $clog2(GAP_SMP + 1);

  logic          prev_q, prev_d;
  logic [NW-1:0] null_q, null_d;
  logic          act;

  always_comb begin
    act     = one | zero;
    clash   = ce & one & zero;
    bit_stb = ce & act & ~prev_q & ~(one & zero);
    bit_val = one;
    gap_stb = ce & ~act & (null_q == NW'(GAP_SMP - 1));
    prev_d  = prev_q;
    null_d  = null_q;
    if (mr) begin
      prev_d = 1'b0;
      null_d = '0;
    end else if (ce) begin
      prev_d = act;
      if (act)
        null_d = '0;
      else if (null_q != NW'(GAP_SMP))
        null_d = null_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      null_q <= '0;
    end else begin
      prev_q <= prev_d;
      null_q <= null_d;
    end
  end
endmodule

// File: rtl/bwr_assembler.sv
module bwr_assembler #(
  parameter int unsigned WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mr,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 clash,
  input  logic                 gap_stb,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 short_err,
  output logic                 long_err
);
  localparam int unsigned CW = $clog2(WORD_BITS + 1);

  logic [WORD_BITS-1:0] shr_q, shr_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 bad_q, bad_d;
  logic                 over_q, over_d;
  logic                 full;

  always_comb begin
    full      = (cnt_q == CW'(WORD_BITS));
    long_err  = bit_stb & full & ~over_q;
    word_done = gap_stb & full & ~bad_q & ~over_q;
    short_err = gap_stb & (cnt_q != '0) & ~full;
    word_data = shr_q;
    shr_d  = shr_q;
    cnt_d  = cnt_q;
    bad_d  = bad_q | clash;
    over_d = over_q | long_err;
    if (bit_stb && !full) begin
      shr_d = {bit_val, shr_q[WORD_BITS-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
    if (gap_stb || mr) begin
      cnt_d  = '0;
      bad_d  = 1'b0;
      over_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_q  <= '0;
      cnt_q  <= '0;
      bad_q  <= 1'b0;
      over_q <= 1'b0;
    end else begin
      shr_q  <= shr_d;
      cnt_q  <= cnt_d;
      bad_q  <= bad_d;
      over_q <= over_d;
    end
  end
endmodule

// File: rtl/bipolar_word_rx.sv
module bipolar_word_rx #(
  parameter int unsigned WORD_BITS   = 32,
  parameter int unsigned SMP_PER_BIT = 4,
  parameter int unsigned NULL_BITS   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mr,
  input  logic                        rx_ce,
  input  logic                        line_one,
  input  logic                        line_zero,
  input  logic                        tx_ce,
  input  logic                        lb_one,
  input  logic                        lb_zero,
  input  logic                        self_test,
  input  logic                        parity_en,
  input  logic                        word_ack,
  input  logic                        stat_rd,
  output logic [WORD_BITS-1:0]        word_out,
  output logic                        word_ready,
  output logic [bwr_pkg::ST_W-1:0]    status,
  output logic                        err_any
);
  import bwr_pkg::*;

  localparam int unsigned GAP_SMP = SMP_PER_BIT * NULL_BITS;

  logic                 s_one, s_zero, s_ce;
  logic                 bit_stb, bit_val, clash, gap_stb;
  logic                 word_done, short_err, long_err;
  logic [WORD_BITS-1:0] word_data;

  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 rdy_q, rdy_d;
  logic                 par_q, par_d, ovw_q, ovw_d, seq_q, seq_d;
  logic                 par_set, ovw_set, seq_set;

  bwr_line_sel u_sel (
    .ext_one  (line_one),
    .ext_zero (line_zero),
    .ext_ce   (rx_ce),
    .lb_one   (lb_one),
    .lb_zero  (lb_zero),
    .lb_ce    (tx_ce),
    .self_test(self_test),
    .smp_one  (s_one),
    .smp_zero (s_zero),
    .smp_ce   (s_ce)
  );

  bwr_pulse_gap #(.GAP_SMP(GAP_SMP)) u_pg (
    .clk    (clk),
    .rst_n  (rst_n),
    .mr     (mr),
    .ce     (s_ce),
    .one    (s_one),
    .zero   (s_zero),
    .bit_stb(bit_stb),
    .bit_val(bit_val),
    .clash  (clash),
    .gap_stb(gap_stb)
  );

  bwr_assembler #(.WORD_BITS(WORD_BITS)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr       (mr),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .clash    (clash),
    .gap_stb  (gap_stb),
    .word_done(word_done),
    .word_data(word_data),
    .short_err(short_err),
    .long_err (long_err)
  );

  always_comb begin
    par_set = word_done & parity_en & ~(^word_data);
    ovw_set = word_done & rdy_q & ~word_ack;
    seq_set = clash | short_err | long_err;
    word_d  = word_done ? word_data : word_q;
    rdy_d   = word_done | (rdy_q & ~word_ack);
    par_d   = par_set | (par_q & ~stat_rd);
    ovw_d   = ovw_set | (ovw_q & ~stat_rd);
    seq_d   = seq_set | (seq_q & ~stat_rd);
    if (mr) begin
      rdy_d = 1'b0;
      par_d = 1'b0;
      ovw_d = 1'b0;
      seq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rdy_q  <= 1'b0;
      par_q  <= 1'b0;
      ovw_q  <= 1'b0;
      seq_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      rdy_q  <= rdy_d;
      par_q  <= par_d;
      ovw_q  <= ovw_d;
      seq_q  <= seq_d;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_PAR] = par_q;
    status[ST_OVW] = ovw_q;
    status[ST_SEQ] = seq_q;
    word_out       = word_q;
    word_ready     = rdy_q;
    err_any        = par_q | ovw_q | seq_q;
  end
endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
  parameter int unsigned WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mr,
  input logic                 rx_ce,
  input logic                 line_one,
  input logic                 line_zero,
  input logic                 self_test,
  input logic                 parity_en,
  input logic                 word_ack,
  input logic                 stat_rd,
  input logic [WORD_BITS-1:0] word_out,
  input logic                 word_ready,
  input logic [7:0]           status
);
  p_clash_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!self_test && rx_ce && line_one && line_zero && !mr) |=> status[5]);

  p_mr_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> (!word_ready && status == 8'h00));

  p_seq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(stat_rd || mr));

  p_par_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) |-> $past(stat_rd || mr));

  p_load_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> word_ready);

  p_ready_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_ready) |-> $past(word_ack || mr));

  p_ovw_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(word_ready));

  p_par_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(parity_en));
endmodule

bind bipolar_word_rx bwr_checker #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mr        (mr),
  .rx_ce     (rx_ce),
  .line_one  (line_one),
  .line_zero (line_zero),
  .self_test (self_test),
  .parity_en (parity_en),
  .word_ack  (word_ack),
  .stat_rd   (stat_rd),
  .word_out  (word_out),
  .word_ready(word_ready),
  .status    (status)
);

// File: tb/test_bipolar_word_rx.sv
module test_bipolar_word_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mr = 1'b0, rx_ce = 1'b1, line_one = 1'b0, line_zero = 1'b0;
  logic        tx_ce = 1'b0, lb_one = 1'b0, lb_zero = 1'b0, self_test = 1'b0;
  logic        parity_en = 1'b0, word_ack = 1'b0, stat_rd = 1'b0;
  logic [31:0] word_out;
  logic        word_ready;
  logic [7:0]  status;
  logic        err_any;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bipolar_word_rx i_bipolar_word_rx (
    .clk(clk), .rst_n(rst_n), .mr(mr), .rx_ce(rx_ce),
    .line_one(line_one), .line_zero(line_zero), .tx_ce(tx_ce),
    .lb_one(lb_one), .lb_zero(lb_zero), .self_test(self_test),
    .parity_en(parity_en), .word_ack(word_ack), .stat_rd(stat_rd),
    .word_out(word_out), .word_ready(word_ready), .status(status),
    .err_any(err_any)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drv(input logic o, input logic z);
    @(negedge clk);
    if (self_test) begin lb_one = o; lb_zero = z; end
    else begin line_one = o; line_zero = z; end
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      drv(w[i % 32], ~w[i % 32]);
      drv(w[i % 32], ~w[i % 32]);
      drv(1'b0, 1'b0);
      drv(1'b0, 1'b0);
    end
  endtask

  task automatic nulls(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, 1'b0);
  endtask

  task automatic ack();
    @(negedge clk); word_ack = 1'b1;
    @(negedge clk); word_ack = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  function automatic logic [7:0] par_exp(input logic [31:0] w, input logic en);
    return (en && ($countones(w) % 2 == 0)) ? 8'h08 : 8'h00;
  endfunction

  task automatic word_case(input string tag, input logic [31:0] w);
    send_bits(w, 32);
    nulls(12);
    chk({tag, " R3 ready"}, {31'd0, word_ready}, 32'd1);
    chk({tag, " R2 word"}, word_out, w);
    chk({tag, " R7 status"}, {24'd0, status}, {24'd0, par_exp(w, parity_en)});
    chk({tag, " R11 err_any"}, {31'd0, err_any}, {31'd0, par_exp(w, parity_en) != 8'h00});
    ack();
    chk({tag, " R9 ack"}, {31'd0, word_ready}, 32'd0);
    rd();
    chk({tag, " R10 read"}, {24'd0, status}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset ready", {31'd0, word_ready}, 32'd0);
    chk("R11 reset status", {24'd0, status}, 32'd0);
    chk("R11 reset err_any", {31'd0, err_any}, 32'd0);

    // R2 R7: single-one words (odd parity good), then two-one words (parity fault)
    parity_en = 1'b1;
    for (int k = 0; k < 32; k++) word_case("R2 single", 32'd1 << k);
    for (int k = 0; k < 32; k++)
      word_case("R7 pair", (32'd1 << k) | (32'd1 << ((k + 5) % 32)));
    parity_en = 1'b0;
    word_case("R7 off", 32'hA5C3_0F96);
    word_case("R2 mixed", 32'h8000_0001);

    // R5 short words
    for (int n = 1; n < 32; n++) begin
      send_bits(32'h6B2D_91E4, n);
      nulls(12);
      chk("R5 short seq", {24'd0, status}, 32'h20);
      chk("R5 short ready", {31'd0, word_ready}, 32'd0);
      rd();
      chk("R10 short clear", {24'd0, status}, 32'd0);
    end

    // R6 overlong
    send_bits(32'h0000_FFFF, 33);
    nulls(12);
    chk("R6 long seq", {24'd0, status}, 32'h20);
    chk("R6 long ready", {31'd0, word_ready}, 32'd0);
    rd();

    // R4 clash inside an otherwise full-length word
    send_bits(32'h1234_5678, 10);
    drv(1'b1, 1'b1); drv(1'b0, 1'b0);
    send_bits(32'h1234_5678, 22);
    nulls(12);
    chk("R4 clash seq", {24'd0, status}, 32'h20);
    chk("R4 clash ready", {31'd0, word_ready}, 32'd0);
    rd();

    // R8 overwrite
    send_bits(32'h1111_0000, 32); nulls(12);
    send_bits(32'h0000_2222, 32); nulls(12);
    chk("R8 ovw status", {24'd0, status}, 32'h10);
    chk("R8 ovw word", word_out, 32'h0000_2222);
    chk("R11 ovw err_any", {31'd0, err_any}, 32'd1);
    ack(); rd();

    // R9 ack in the completion cycle
    send_bits(32'hCAFE_0001, 32); nulls(12);
    send_bits(32'h0BAD_F00D, 32); nulls(9);
    drv(1'b0, 1'b0); word_ack = 1'b1;
    drv(1'b0, 1'b0); word_ack = 1'b0;
    chk("R9 same ready", {31'd0, word_ready}, 32'd1);
    chk("R9 same word", word_out, 32'h0BAD_F00D);
    chk("R9 same status", {24'd0, status}, 32'd0);
    ack(); nulls(4);

    // R10 read coinciding with a new clash
    parity_en = 1'b1;
    send_bits(32'h0000_0003, 32); nulls(12);
    chk("R7 setup", {24'd0, status}, 32'h08);
    ack();
    drv(1'b1, 1'b1); stat_rd = 1'b1;
    drv(1'b0, 1'b0); stat_rd = 1'b0;
    chk("R10 set wins", {24'd0, status}, 32'h20);
    nulls(12); rd();

    // R12 master reset mid-word
    send_bits(32'h0000_0003, 32); nulls(12);
    send_bits(32'hFFFF_FFFF, 16);
    @(negedge clk); mr = 1'b1;
    @(negedge clk); mr = 1'b0;
    chk("R12 mr ready", {31'd0, word_ready}, 32'd0);
    chk("R12 mr status", {24'd0, status}, 32'd0);
    send_bits(32'h7000_0000, 32); nulls(12);
    chk("R12 fresh ready", {31'd0, word_ready}, 32'd1);
    chk("R12 fresh word", word_out, 32'h7000_0000);
    chk("R12 fresh status", {24'd0, status}, 32'd0);
    ack();
    parity_en = 1'b0;

    // R1 gated sample enable
    @(negedge clk); rx_ce = 1'b0;
    send_bits(32'h5555_AAAA, 32); nulls(12);
    chk("R1 gated ready", {31'd0, word_ready}, 32'd0);
    chk("R1 gated status", {24'd0, status}, 32'd0);
    @(negedge clk); rx_ce = 1'b1;
    nulls(12);

    // R13 loopback with external lines clashing and rx_ce low
    @(negedge clk);
    self_test = 1'b1; tx_ce = 1'b1; rx_ce = 1'b0;
    line_one = 1'b1; line_zero = 1'b1;
    nulls(12);
    send_bits(32'h1234_5679, 32); nulls(12);
    chk("R13 st ready", {31'd0, word_ready}, 32'd1);
    chk("R13 st word", word_out, 32'h1234_5679);
    chk("R13 st status", {24'd0, status}, 32'd0);
    ack();
    @(negedge clk);
    line_one = 1'b0; line_zero = 1'b0;
    @(negedge clk);
    self_test = 1'b0; tx_ce = 1'b0; rx_ce = 1'b1;
    nulls(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule